// File: doc/BRIEF.md
# Victim Line Buffer

This block sits beside a direct-mapped cache and keeps a few of the lines that the cache throws out when it replaces a block. The buffer is fully associative: every entry holds a complete block address as its tag, and all entries are compared against a probe address at the same time. The primary cache consults the buffer only after its own lookup has missed. In that lookup it also presents the line that currently sits in the slot it wants to refill.

If the probe hits, the buffer returns the stored line one cycle later, and the displaced primary line takes over the entry that has just been emptied. This is a swap, and no lower-level access is made. If the probe misses, the buffer raises a fill request toward lower memory and stays busy until the response arrives. It then hands the returned line back on the same response port.

Lines evicted by ordinary refills enter through a separate insert port. They are written at a ring pointer, so once every entry is full a new line overwrites the oldest insertion.

Top module: `victim_buffer`

## Requirements
- R1: After synchronous reset every entry is invalid, `rsp_valid`, `mem_req_valid` and `busy` are low, and a lookup of any address previously inserted misses.
- R2: When `ins_valid` is high and `lk_valid` is low, the line with its block address is written to the entry at the ring pointer and the pointer advances (wrapping). Reset sets the pointer to entry 0.
- R3: An insert presented in the same cycle as `lk_valid` is ignored; its address is not found by later lookups.
- R4: A lookup is accepted when `lk_valid` is high and `busy` is low. A hit in any valid entry gives, on the following cycle, `rsp_valid`=1, `rsp_hit`=1 and `rsp_line` equal to the stored line.
- R5: A lookup that hits never raises `mem_req_valid`.
- R6: On a hit, the hit entry takes the displaced line and its address if `lk_disp_valid` is 1; if not, the entry becomes invalid.
- R7: A lookup that misses gives, on the following cycle, `mem_req_valid`=1, `mem_req_addr` equal to the probe address and `busy`=1, with no response. The request and its address are held until `mem_rsp_valid`.
- R8: `mem_rsp_valid` while busy gives, on the following cycle, `rsp_valid`=1, `rsp_hit`=0 and `rsp_line` equal to `mem_rsp_line`, with `mem_req_valid` and `busy` low.
- R9: A lookup presented while `busy` is high produces no response and leaves all entries unchanged.
- R10: With all entries filled by inserts since reset, a further insert replaces the least recently inserted line.
- R11: The tag is the full block address; an address differing from a stored one in any bit, including the top bit, misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Probe request after a primary miss |
| lk_addr | input | ADDR_W | Block address being probed |
| lk_disp_valid | input | 1 | The primary slot holds a line to hand over on a swap |
| lk_disp_addr | input | ADDR_W | Block address of the displaced primary line |
| lk_disp_line | input | LINE_W | Data of the displaced primary line |
| busy | output | 1 | Fill outstanding; probes are not accepted |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Response came from the buffer (1) or from lower memory (0) |
| rsp_line | output | LINE_W | Returned line |
| ins_valid | input | 1 | Evicted line offered for storage |
| ins_addr | input | ADDR_W | Block address of the evicted line |
| ins_line | input | LINE_W | Data of the evicted line |
| mem_req_valid | output | 1 | Fill request toward lower memory |
| mem_req_addr | output | ADDR_W | Block address to fetch |
| mem_rsp_valid | input | 1 | Fill data present |
| mem_rsp_line | input | LINE_W | Fill data |

## Verification
The stimulus mixes probes that hit a freshly inserted line, probes that hit a line placed there by an earlier swap, probes that hit an entry a swap has just invalidated, and probes of addresses that were overwritten by the ring pointer. These separate a wrong compare, a wrong swap write and a wrong replacement choice. Addresses that differ from a stored one only in the top bit show whether the tag is truncated. Directed cases cover the following: an insert colliding with a probe, a probe arriving during a pending fill, and a reset that must forget every stored line. In each case the outcome is observed through later probes.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic {
    VC_IDLE = 1'b0,
    VC_WAIT = 1'b1
  } vc_state_e;
endpackage

// File: rtl/vc_tag_array.sv
module vc_tag_array #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int IDX_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  logic [ENTRIES-1:0] match;

  // one tag register and comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              vld_q;
    logic [ADDR_W-1:0] tag_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
        tag_q <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        vld_q <= wr_valid;
        tag_q <= wr_addr;
      end
    end
    assign match[g] = vld_q && (tag_q == probe_addr);
  end

  assign hit = |match;

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vc_line_store.sv
module vc_line_store #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 64,
  parameter int IDX_W   = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line
);
  logic [LINE_W-1:0] mem [ENTRIES];

  // read-before-write so a swap returns the old line
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_line;
    if (rd_en) rd_line <= mem[rd_idx];
  end
endmodule

// File: rtl/vc_ring_ptr.sv
module vc_ring_ptr #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (advance) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int LINE_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_disp_valid,
  input  logic [ADDR_W-1:0] lk_disp_addr,
  input  logic [LINE_W-1:0] lk_disp_line,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [LINE_W-1:0] rsp_line,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [LINE_W-1:0] ins_line,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_line
);
  import vc_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  vc_state_e         state_q;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [IDX_W-1:0]  ptr;
  logic              accept, swap, ins_take, wr_en, wr_valid;
  logic [IDX_W-1:0]  wr_idx;
  logic [ADDR_W-1:0] wr_addr;
  logic [LINE_W-1:0] wr_line;
  logic [LINE_W-1:0] store_line;
  logic [LINE_W-1:0] fill_line_q;
  logic              from_mem_q;

  assign accept   = lk_valid && (state_q == VC_IDLE);
  assign swap     = accept && hit;
  assign ins_take = ins_valid && !lk_valid;
  assign wr_en    = swap || ins_take;
  assign wr_idx   = swap ? hit_idx : ptr;
  assign wr_valid = swap ? lk_disp_valid : 1'b1;
  assign wr_addr  = swap ? lk_disp_addr : ins_addr;
  assign wr_line  = swap ? lk_disp_line : ins_line;

  vc_tag_array #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_tags (
    .clk        (clk),
    .rst        (rst),
    .probe_addr (lk_addr),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .hit        (hit),
    .hit_idx    (hit_idx)
  );

  vc_line_store #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_lines (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_line (wr_line),
    .rd_en   (swap),
    .rd_idx  (hit_idx),
    .rd_line (store_line)
  );

  vc_ring_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .advance (ins_take),
    .ptr     (ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= VC_IDLE;
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      from_mem_q    <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      fill_line_q   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        VC_IDLE: begin
          if (accept) begin
            if (hit) begin
              rsp_valid  <= 1'b1;
              rsp_hit    <= 1'b1;
              from_mem_q <= 1'b0;
            end else begin
              mem_req_valid <= 1'b1;
              mem_req_addr  <= lk_addr;
              state_q       <= VC_WAIT;
            end
          end
        end
        VC_WAIT: begin
          if (mem_rsp_valid) begin
            mem_req_valid <= 1'b0;
            rsp_valid     <= 1'b1;
            rsp_hit       <= 1'b0;
            from_mem_q    <= 1'b1;
            fill_line_q   <= mem_rsp_line;
            state_q       <= VC_IDLE;
          end
        end
        default: state_q <= VC_IDLE;
      endcase
    end
  end

  assign busy     = (state_q == VC_WAIT);
  assign rsp_line = from_mem_q ? fill_line_q : store_line;
endmodule

// File: rtl/victim_buffer_chk.sv
module victim_buffer_chk #(
  parameter int ADDR_W = 26
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic              busy,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!rsp_valid && !mem_req_valid && !busy));

  // R5
  hit_no_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> !mem_req_valid);

  // R8
  resp_clears_req_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !mem_req_valid);

  // R7
  req_held_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R4
  probe_answered_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !busy) |=> (rsp_valid || mem_req_valid));

  // R9
  busy_probe_dropped_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && busy && !mem_rsp_valid) |=> !rsp_valid);
endmodule

bind victim_buffer victim_buffer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .lk_valid      (lk_valid),
  .busy          (busy),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .mem_req_valid (mem_req_valid),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/victim_buffer_test.sv
module victim_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 26;
  localparam int LW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lk_valid = 1'b0, lk_disp_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0, lk_disp_addr = '0;
  logic [LW-1:0] lk_disp_line = '0;
  logic          busy, rsp_valid, rsp_hit;
  logic [LW-1:0] rsp_line;
  logic          ins_valid = 1'b0;
  logic [AW-1:0] ins_addr = '0;
  logic [LW-1:0] ins_line = '0;
  logic          mem_req_valid;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [LW-1:0] mem_rsp_line = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  victim_buffer #(.ENTRIES(4), .ADDR_W(AW), .LINE_W(LW)) uut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_disp_valid(lk_disp_valid),
    .lk_disp_addr(lk_disp_addr), .lk_disp_line(lk_disp_line),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_line(rsp_line),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_line(ins_line),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line)
  );

  function automatic logic [LW-1:0] pat(input logic [AW-1:0] a);
    return {6'h00, a, 6'h3F, a};
  endfunction

  task automatic check(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic insert(input logic [AW-1:0] a);
    @(negedge clk);
    ins_valid = 1'b1; ins_addr = a; ins_line = pat(a);
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic respond(input logic [AW-1:0] a);
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_line = ~pat(a);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    check(rsp_valid && !rsp_hit && !busy && !mem_req_valid, "R8 fill response",
          {60'h0, rsp_valid, rsp_hit, busy, mem_req_valid}, 64'h8);
    check(rsp_line == ~pat(a), "R8 fill line", rsp_line, ~pat(a));
  endtask

  task automatic probe(input logic [AW-1:0] a, input bit dv, input logic [AW-1:0] da,
                       input bit exp_hit, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_disp_valid = dv;
    lk_disp_addr = da; lk_disp_line = pat(da);
    @(negedge clk);
    lk_valid = 1'b0;
    if (exp_hit) begin
      check(rsp_valid && rsp_hit && !mem_req_valid, {req, " hit, no fetch (R5)"},
            {61'h0, rsp_valid, rsp_hit, mem_req_valid}, 64'h6);
      check(rsp_line == pat(a), {req, " hit line"}, rsp_line, pat(a));
    end else begin
      check(!rsp_valid && mem_req_valid && busy, {req, " miss raises request (R7)"},
            {61'h0, rsp_valid, mem_req_valid, busy}, 64'h3);
      check(mem_req_addr == a, {req, " request address (R7)"}, LW'(mem_req_addr), LW'(a));
      @(negedge clk);
      check(mem_req_valid && !rsp_valid && mem_req_addr == a, "R7 request held",
            {62'h0, mem_req_valid, rsp_valid}, 64'h2);
      respond(a);
    end
  endtask

  typedef struct packed {
    logic          is_probe;
    logic [AW-1:0] addr;
    logic          dv;
    logic [AW-1:0] daddr;
    logic          exp_hit;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 26'h0000100, 1'b0, 26'h0, 1'b0},  // insert A -> entry 0
    '{1'b0, 26'h0000200, 1'b0, 26'h0, 1'b0},  // insert B -> entry 1
    '{1'b1, 26'h0000100, 1'b1, 26'h0000300, 1'b1},  // R4 R6 hit A, D swapped in
    '{1'b1, 26'h0000100, 1'b0, 26'h0, 1'b0},  // R6 A left the buffer
    '{1'b1, 26'h0000300, 1'b0, 26'h0, 1'b1},  // R6 D found, entry invalidated
    '{1'b1, 26'h0000300, 1'b0, 26'h0, 1'b0},  // R6 D gone
    '{1'b0, 26'h0000400, 1'b0, 26'h0, 1'b0},  // insert C -> entry 2
    '{1'b0, 26'h0000500, 1'b0, 26'h0, 1'b0},  // insert E -> entry 3
    '{1'b0, 26'h0000600, 1'b0, 26'h0, 1'b0},  // R2 insert F wraps to entry 0
    '{1'b0, 26'h0000700, 1'b0, 26'h0, 1'b0},  // R2 insert G -> entry 1, B lost
    '{1'b1, 26'h0000200, 1'b0, 26'h0, 1'b0},  // R2 B overwritten
    '{1'b1, 26'h0000400, 1'b1, 26'h0000800, 1'b1},  // R4 C hit, H swapped in
    '{1'b1, 26'h0000800, 1'b1, 26'h0000800, 1'b1},  // R6 H hit, stays
    '{1'b1, 26'h0000700, 1'b1, 26'h0000700, 1'b1},  // R4 G
    '{1'b1, 26'h0000600, 1'b1, 26'h0000600, 1'b1},  // R4 F
    '{1'b1, 26'h2000500, 1'b0, 26'h0, 1'b0},  // R11 top bit differs
    '{1'b1, 26'h0000501, 1'b0, 26'h0, 1'b0},  // R11 low bit differs
    '{1'b1, 26'h0000500, 1'b1, 26'h0000500, 1'b1},  // R11 exact match
    '{1'b1, 26'h0000400, 1'b0, 26'h0, 1'b0}   // C moved out on swap
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!rsp_valid && !mem_req_valid && !busy, "R1 idle after reset",
          {61'h0, rsp_valid, mem_req_valid, busy}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_probe)
        probe(VECS[i].addr, VECS[i].dv, VECS[i].daddr, VECS[i].exp_hit, $sformatf("vec%0d", i));
      else
        insert(VECS[i].addr);
    end

    // R3: insert colliding with a probe is dropped
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 26'h0000700; lk_disp_valid = 1'b1;
    lk_disp_addr = 26'h0000700; lk_disp_line = pat(26'h0000700);
    ins_valid = 1'b1; ins_addr = 26'h0000A00; ins_line = pat(26'h0000A00);
    @(negedge clk);
    lk_valid = 1'b0; ins_valid = 1'b0;
    check(rsp_valid && rsp_hit, "R3 probe served", {62'h0, rsp_valid, rsp_hit}, 64'h3);
    probe(26'h0000A00, 1'b0, 26'h0, 1'b0, "R3 dropped insert absent");

    // R9: probe during a pending fill is ignored
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 26'h0000B00; lk_disp_valid = 1'b0;
    @(negedge clk);
    lk_addr = 26'h0000700; lk_disp_valid = 1'b0;
    check(busy && mem_req_addr == 26'h0000B00, "R9 busy with fill", {63'h0, busy}, 64'h1);
    @(negedge clk);
    lk_valid = 1'b0;
    check(!rsp_valid, "R9 no response while busy", {63'h0, rsp_valid}, 64'h0);
    respond(26'h0000B00);
    probe(26'h0000700, 1'b1, 26'h0000700, 1'b1, "R9 entry untouched");

    // R1: reset forgets stored lines
    insert(26'h0000C00);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(!rsp_valid && !mem_req_valid && !busy, "R1 idle after second reset",
          {61'h0, rsp_valid, mem_req_valid, busy}, 64'h0);
    probe(26'h0000C00, 1'b0, 26'h0, 1'b0, "R1 cleared");

    // R10: fifth insert after reset evicts the first
    for (int k = 1; k <= 5; k++) insert(AW'(k * 16));
    probe(26'h0000010, 1'b0, 26'h0, 1'b0, "R10 oldest evicted");
    probe(26'h0000020, 1'b1, 26'h0000020, 1'b1, "R10 second kept");
    probe(26'h0000050, 1'b1, 26'h0000050, 1'b1, "R10 newest kept");

    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end
endmodule